// File: doc/BRIEF.md
# Dual-Channel Load-Switch Fault Supervisor

This block is the digital control core for a pair of high-side load switches. Each channel has a request input from the host and a set of digital flags from analog comparators: overcurrent, open load seen while on, open load seen while off, and overtemperature. A shared supply-overvoltage flag, a mode input that suppresses latch-off on overcurrent, and a chip-enable act on both channels. From these the block drives one gate-enable per channel, one active-low fault status per channel and one shared active-low interrupt. The status and interrupt outputs each come with an output-enable, so the pad ring can tri-state them while the chip sleeps.

Every asynchronous input passes through a synchronizer whose depth is a parameter. The short-sense window, the refresh (retry) time and the open-load sense time are parameters in clock cycles, so a fast simulation can use short values while silicon uses the microsecond and millisecond values. Per channel, a small state machine tracks idle, driving, retry-off and post-retry check phases, and separate filters declare the timed faults.

Top module: `hsw_fault_sup`

## Requirements
- R1: A gate-enable is high only while the chip-enable is high, that channel's request is high, and neither a global nor a channel shutdown is active; with all of these met the gate is on.
- R2: While the chip-enable is low both gate-enables are low, `stat_oe` and `int_oe` are low (status and interrupt in high impedance), and every latched fault is cleared, so nothing is reported after re-enable.
- R3: Overcurrent on a driven channel is ignored until it has persisted for SHORT_CYC consecutive synchronized cycles; only then is an overcurrent fault declared.
- R4: With `no_latch` low, a declared overcurrent fault turns off only the affected channel; the other channel keeps following its own request.
- R5: After latch-off the channel stays off for REFRESH_CYC cycles, then turns on again; if overcurrent persists for another SHORT_CYC cycles it turns off for another refresh period, repeating while the request stays high.
- R6: With `no_latch` high, a declared overcurrent fault is reported but the channel stays on; the fault clears once the overcurrent flag drops.
- R7: A latched overcurrent fault stays reported through the retry; it clears after a refresh is followed by SHORT_CYC driven cycles free of overcurrent, or at once when that channel's request falls.
- R8: An on-state open-load fault is reported when the open-while-on flag stays set for OPEN_CYC cycles while the channel is driven; it does not turn the channel off and clears as soon as the flag drops.
- R9: An off-state open-load fault is reported while the channel request is low and the open-while-off flag is set; it clears when the flag drops or the request rises.
- R10: The overvoltage flag turns both gates off regardless of requests and pulls both status outputs low; when it clears, channels with a high request turn back on and the status returns high.
- R11: Overtemperature turns off only that channel and reports a fault at once; when the flag clears the channel turns on again if requested, and with the request low the fault clears once the flag is low.
- R12: Status outputs are high for no fault and low for a fault; `int_n` is low whenever either status is low and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low selects sleep |
| no_latch | input | 1 | High keeps a channel on under overcurrent |
| ovp_flag | input | 1 | Supply overvoltage comparator flag |
| req | input | NCH | Per-channel on request |
| oc_flag | input | NCH | Per-channel overcurrent flag |
| open_on_flag | input | NCH | Per-channel open load while on flag |
| open_off_flag | input | NCH | Per-channel open load while off flag |
| hot_flag | input | NCH | Per-channel overtemperature flag |
| gate_en | output | NCH | Per-channel switch gate enable |
| stat_n | output | NCH | Per-channel fault status, active low |
| stat_oe | output | 1 | Output enable of the status pins |
| int_n | output | 1 | Shared fault interrupt, active low |
| int_oe | output | 1 | Output enable of the interrupt pin |

## Verification
A state machine stuck in or wrongly leaving its retry phase shows at the gate-enable within one refresh period, as a channel that stays dark or never goes dark under sustained overcurrent. A short-sense or open-load counter with the wrong terminal value moves the first low on the status pin by that many cycles, so the bench samples just before and just after the expected edge. A fault bit that fails to clear shows on the status and interrupt pins a few cycles after its clearing condition, and a missing sleep clear shows as a status low right after the chip is re-enabled.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   typedef enum logic [1:0] {
      CH_OFF   = 2'd0,
      CH_ON    = 2'd1,
      CH_RETRY = 2'd2,
      CH_CHECK = 2'd3
   } ch_state_e;

   typedef struct packed {
      logic oc;
      logic hot;
      logic open_on;
      logic open_off;
   } ch_fault_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("hsw_sync: W must be at least 1");
      end
      if (STAGES < 2) begin : g_bad_stages
         $error("hsw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/hsw_chan.sv
module hsw_chan
   import hsw_pkg::*;
#(
   parameter int SHORT_CYC   = 8,
   parameter int REFRESH_CYC = 20,
   parameter int OPEN_CYC    = 6
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      ov,
   input  logic      no_latch,
   input  logic      req,
   input  logic      oc,
   input  logic      open_on,
   input  logic      open_off,
   input  logic      hot,
   output logic      gate,
   output ch_fault_t fault
);

   localparam int MAXC = max3(SHORT_CYC, REFRESH_CYC, OPEN_CYC);
   localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
   localparam logic [CW-1:0] SHORT_LAST   = CW'(SHORT_CYC - 1);
   localparam logic [CW-1:0] REFRESH_LAST = CW'(REFRESH_CYC - 1);
   localparam logic [CW-1:0] OPEN_LAST    = CW'(OPEN_CYC - 1);

   generate
      if (SHORT_CYC < 2 || REFRESH_CYC < 2 || OPEN_CYC < 2) begin : g_bad_timer
         $error("hsw_chan: every timer length must be at least 2 cycles");
      end
   endgenerate

   ch_state_e state_q, state_d;
   logic [CW-1:0] oc_cnt_q, oc_cnt_d;
   logic [CW-1:0] ref_cnt_q, ref_cnt_d;
   logic [CW-1:0] clr_cnt_q, clr_cnt_d;
   logic [CW-1:0] opn_cnt_q, opn_cnt_d;
   logic          oc_flt_d, opn_flt_d;
   logic          drive;
   logic          gate_d;

   // channel drives when its phase allows it and no shutdown is present
   assign drive  = ((state_q == CH_ON) || (state_q == CH_CHECK)) && !ov && !hot;
   assign gate_d = en && req && drive;

   // overcurrent / retry sequencing
   always_comb begin
      state_d   = state_q;
      oc_cnt_d  = oc_cnt_q;
      ref_cnt_d = ref_cnt_q;
      clr_cnt_d = clr_cnt_q;
      oc_flt_d  = fault.oc;
      if (!en || !req) begin
         state_d   = CH_OFF;
         oc_cnt_d  = '0;
         ref_cnt_d = '0;
         clr_cnt_d = '0;
         oc_flt_d  = 1'b0;
      end else begin
         unique case (state_q)
            CH_OFF: begin
               state_d  = CH_ON;
               oc_cnt_d = '0;
            end
            CH_ON: begin
               if (drive && oc) begin
                  if (oc_cnt_q == SHORT_LAST) begin
                     oc_flt_d = 1'b1;
                     oc_cnt_d = '0;
                     if (!no_latch) begin
                        state_d   = CH_RETRY;
                        ref_cnt_d = '0;
                     end
                  end else begin
                     oc_cnt_d = oc_cnt_q + 1'b1;
                  end
               end else begin
                  oc_cnt_d = '0;
                  if (!oc) oc_flt_d = 1'b0;
               end
            end
            CH_RETRY: begin
               if (ref_cnt_q == REFRESH_LAST) begin
                  state_d   = CH_CHECK;
                  oc_cnt_d  = '0;
                  clr_cnt_d = '0;
               end else begin
                  ref_cnt_d = ref_cnt_q + 1'b1;
               end
            end
            CH_CHECK: begin
               if (drive && oc) begin
                  clr_cnt_d = '0;
                  if (oc_cnt_q == SHORT_LAST) begin
                     state_d   = CH_RETRY;
                     ref_cnt_d = '0;
                     oc_cnt_d  = '0;
                  end else begin
                     oc_cnt_d = oc_cnt_q + 1'b1;
                  end
               end else if (drive) begin
                  oc_cnt_d = '0;
                  if (clr_cnt_q == SHORT_LAST) begin
                     state_d   = CH_ON;
                     oc_flt_d  = 1'b0;
                     clr_cnt_d = '0;
                  end else begin
                     clr_cnt_d = clr_cnt_q + 1'b1;
                  end
               end else begin
                  oc_cnt_d  = '0;
                  clr_cnt_d = '0;
               end
            end
            default: state_d = CH_OFF;
         endcase
      end
   end

   // open-load filter while driven
   always_comb begin
      opn_cnt_d = '0;
      opn_flt_d = 1'b0;
      if (en && drive && open_on) begin
         if (opn_cnt_q == OPEN_LAST) begin
            opn_cnt_d = opn_cnt_q;
            opn_flt_d = 1'b1;
         end else begin
            opn_cnt_d = opn_cnt_q + 1'b1;
            opn_flt_d = fault.open_on;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= CH_OFF;
         oc_cnt_q  <= '0;
         ref_cnt_q <= '0;
         clr_cnt_q <= '0;
         opn_cnt_q <= '0;
         gate      <= 1'b0;
         fault     <= '0;
      end else begin
         state_q        <= state_d;
         oc_cnt_q       <= oc_cnt_d;
         ref_cnt_q      <= ref_cnt_d;
         clr_cnt_q      <= clr_cnt_d;
         opn_cnt_q      <= opn_cnt_d;
         gate           <= gate_d;
         fault.oc       <= oc_flt_d;
         fault.open_on  <= opn_flt_d;
         fault.hot      <= en && hot;
         fault.open_off <= en && !req && open_off;
      end
   end

   AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !gate);  // R2
   AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !gate);  // R1
   AST_OV_SHUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ov |=> !gate);  // R10
   AST_HOT_SHUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      hot |=> !gate);  // R11
   AST_RETRY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_RETRY) |=> !gate);  // R5
   AST_NO_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (no_latch && state_q == CH_ON) |=> (state_q != CH_RETRY));  // R6
   AST_OC_FLT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !fault.oc);  // R7

endmodule

// File: rtl/hsw_fault_sup.sv
module hsw_fault_sup
   import hsw_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int SYNC_STAGES = 2,
   parameter int SHORT_CYC   = 6750,
   parameter int REFRESH_CYC = 500000,
   parameter int OPEN_CYC    = 1250
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           chip_en,
   input  logic           no_latch,
   input  logic           ovp_flag,
   input  logic [NCH-1:0] req,
   input  logic [NCH-1:0] oc_flag,
   input  logic [NCH-1:0] open_on_flag,
   input  logic [NCH-1:0] open_off_flag,
   input  logic [NCH-1:0] hot_flag,
   output logic [NCH-1:0] gate_en,
   output logic [NCH-1:0] stat_n,
   output logic           stat_oe,
   output logic           int_n,
   output logic           int_oe
);

   localparam int SW = 3 + 5 * NCH;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("hsw_fault_sup: NCH must be at least 1");
      end
   endgenerate

   logic [SW-1:0]  raw_v, syn_v;
   logic           en_s, nl_s, ov_s;
   logic [NCH-1:0] req_s, oc_s, opn_on_s, opn_off_s, hot_s;
   logic [NCH-1:0] stat_n_d;
   ch_fault_t      flt [NCH];

   assign raw_v = {chip_en, no_latch, ovp_flag, req, oc_flag,
                   open_on_flag, open_off_flag, hot_flag};

   hsw_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_v),
      .q     (syn_v)
   );

   assign {en_s, nl_s, ov_s, req_s, oc_s, opn_on_s, opn_off_s, hot_s} = syn_v;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         hsw_chan #(
            .SHORT_CYC   (SHORT_CYC),
            .REFRESH_CYC (REFRESH_CYC),
            .OPEN_CYC    (OPEN_CYC)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_s),
            .ov       (ov_s),
            .no_latch (nl_s),
            .req      (req_s[c]),
            .oc       (oc_s[c]),
            .open_on  (opn_on_s[c]),
            .open_off (opn_off_s[c]),
            .hot      (hot_s[c]),
            .gate     (gate_en[c]),
            .fault    (flt[c])
         );
         assign stat_n_d[c] = !en_s || !((|flt[c]) || ov_s);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_n  <= '1;
         int_n   <= 1'b1;
         stat_oe <= 1'b0;
         int_oe  <= 1'b0;
      end else begin
         stat_n  <= stat_n_d;
         int_n   <= &stat_n_d;
         stat_oe <= en_s;
         int_oe  <= en_s;
      end
   end

   AST_INT_FOLLOWS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (int_n == &stat_n));  // R12
   AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (!stat_oe && !int_oe && stat_n == '1));  // R2
   AST_OV_STAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && ov_s) |=> (stat_n == '0));  // R10

endmodule

// File: tb/tb_hsw_fault_sup.sv
module tb_hsw_fault_sup;

   localparam int NCH = 2;
   localparam int S   = 8;
   localparam int R   = 20;
   localparam int O   = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           chip_en = 1'b0;
   logic           no_latch = 1'b0;
   logic           ovp_flag = 1'b0;
   logic [NCH-1:0] req = '0;
   logic [NCH-1:0] oc_flag = '0;
   logic [NCH-1:0] open_on_flag = '0;
   logic [NCH-1:0] open_off_flag = '0;
   logic [NCH-1:0] hot_flag = '0;
   logic [NCH-1:0] gate_en;
   logic [NCH-1:0] stat_n;
   logic           stat_oe;
   logic           int_n;
   logic           int_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   hsw_fault_sup #(
      .NCH(NCH), .SYNC_STAGES(2),
      .SHORT_CYC(S), .REFRESH_CYC(R), .OPEN_CYC(O)
   ) dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .no_latch(no_latch),
      .ovp_flag(ovp_flag), .req(req), .oc_flag(oc_flag),
      .open_on_flag(open_on_flag), .open_off_flag(open_off_flag),
      .hot_flag(hot_flag), .gate_en(gate_en), .stat_n(stat_n),
      .stat_oe(stat_oe), .int_n(int_n), .int_oe(int_oe)
   );

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      req = '0; oc_flag = '0; open_on_flag = '0; open_off_flag = '0;
      hot_flag = '0; ovp_flag = 1'b0; no_latch = 1'b0; chip_en = 1'b1;
      wcyc(8);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      wcyc(3);
      chk("R2 reset gate", gate_en, 2'b00);
      chk("R2 reset stat_oe", stat_oe, 1'b0);
      rst_n = 1'b1;
      chip_en = 1'b1;
      wcyc(6);
      chk("R12 idle stat", stat_n, 2'b11);
      chk("R12 idle int", int_n, 1'b1);
      chk("R2 enabled oe", {stat_oe, int_oe}, 2'b11);
   endtask

   task automatic t_basic();
      settle();
      req = 2'b01; wcyc(6);
      chk("R1 ch0 only", gate_en, 2'b01);
      req = 2'b11; wcyc(6);
      chk("R1 both on", gate_en, 2'b11);
      req = 2'b00; wcyc(6);
      chk("R1 both off", gate_en, 2'b00);
   endtask

   task automatic t_short_retry();
      settle();
      req = 2'b11; wcyc(6);
      oc_flag[0] = 1'b1;
      wcyc(S - 1);
      chk("R3 not yet declared", gate_en[0], 1'b1);
      wcyc(5);
      chk("R4 ch0 latched off", gate_en[0], 1'b0);
      chk("R4 ch1 unaffected", gate_en[1], 1'b1);
      chk("R7 stat ch0 low", stat_n, 2'b10);
      chk("R12 int low", int_n, 1'b0);
      wcyc(8);
      chk("R5 dark in refresh", gate_en[0], 1'b0);
      wcyc(13);
      chk("R5 retry on", gate_en[0], 1'b1);
      chk("R7 held through retry", stat_n[0], 1'b0);
      wcyc(9);
      chk("R5 second latch-off", gate_en[0], 1'b0);
      oc_flag[0] = 1'b0;
      wcyc(18);
      chk("R5 retry after clear", gate_en[0], 1'b1);
      chk("R7 held during check", stat_n[0], 1'b0);
      wcyc(22);
      chk("R7 cleared after clean run", stat_n[0], 1'b1);
      chk("R12 int back high", int_n, 1'b1);
      req = 2'b00;
   endtask

   task automatic t_req_fall();
      settle();
      req[0] = 1'b1; wcyc(6);
      oc_flag[0] = 1'b1;
      wcyc(S + 6);
      chk("R7 fault before fall", stat_n[0], 1'b0);
      req[0] = 1'b0;
      wcyc(5);
      chk("R7 cleared by request fall", stat_n[0], 1'b1);
      oc_flag[0] = 1'b0;
   endtask

   task automatic t_no_latch();
      settle();
      no_latch = 1'b1;
      req[1] = 1'b1; wcyc(6);
      oc_flag[1] = 1'b1;
      wcyc(S + 6);
      chk("R6 stays on", gate_en[1], 1'b1);
      chk("R6 fault reported", stat_n[1], 1'b0);
      wcyc(R + 5);
      chk("R6 still on after refresh time", gate_en[1], 1'b1);
      oc_flag[1] = 1'b0;
      wcyc(5);
      chk("R6 fault clears", stat_n[1], 1'b1);
   endtask

   task automatic t_open_on();
      settle();
      req[1] = 1'b1; wcyc(6);
      open_on_flag[1] = 1'b1;
      wcyc(O - 1);
      chk("R8 not yet reported", stat_n[1], 1'b1);
      wcyc(6);
      chk("R8 reported", stat_n[1], 1'b0);
      chk("R8 gate kept on", gate_en[1], 1'b1);
      open_on_flag[1] = 1'b0;
      wcyc(5);
      chk("R8 cleared", stat_n[1], 1'b1);
   endtask

   task automatic t_open_off();
      settle();
      open_off_flag[0] = 1'b1;
      wcyc(5);
      chk("R9 reported while off", stat_n, 2'b10);
      chk("R12 int low for open", int_n, 1'b0);
      req[0] = 1'b1; wcyc(6);
      chk("R9 not reported while on", stat_n[0], 1'b1);
      req[0] = 1'b0; wcyc(6);
      chk("R9 back when off", stat_n[0], 1'b0);
      open_off_flag[0] = 1'b0; wcyc(5);
      chk("R9 clears with flag", stat_n[0], 1'b1);
   endtask

   task automatic t_hot();
      settle();
      req = 2'b11; wcyc(6);
      hot_flag[0] = 1'b1; wcyc(5);
      chk("R11 ch0 off", gate_en, 2'b10);
      chk("R11 fault ch0", stat_n, 2'b10);
      hot_flag[0] = 1'b0; wcyc(6);
      chk("R11 resumes", gate_en, 2'b11);
      chk("R11 cleared", stat_n, 2'b11);
      req[0] = 1'b0; wcyc(4);
      hot_flag[0] = 1'b1; wcyc(5);
      chk("R11 fault with request low", stat_n[0], 1'b0);
      hot_flag[0] = 1'b0; wcyc(5);
      chk("R11 clears with request low", stat_n[0], 1'b1);
   endtask

   task automatic t_ov();
      settle();
      req = 2'b11; wcyc(6);
      ovp_flag = 1'b1; wcyc(5);
      chk("R10 both off", gate_en, 2'b00);
      chk("R10 both stat low", stat_n, 2'b00);
      chk("R12 int low on ov", int_n, 1'b0);
      ovp_flag = 1'b0; wcyc(6);
      chk("R10 resume", gate_en, 2'b11);
      chk("R10 stat high", stat_n, 2'b11);
   endtask

   task automatic t_sleep();
      settle();
      req = 2'b01;
      open_off_flag[1] = 1'b1;
      wcyc(6);
      chk("R9 ch1 open before sleep", stat_n[1], 1'b0);
      chip_en = 1'b0; wcyc(6);
      chk("R2 gates off in sleep", gate_en, 2'b00);
      chk("R2 outputs tri-stated", {stat_oe, int_oe}, 2'b00);
      open_off_flag[1] = 1'b0;
      chip_en = 1'b1; wcyc(6);
      chk("R1 on after enable", gate_en, 2'b01);
      chk("R2 no stale fault", stat_n, 2'b11);
   endtask

   initial begin
      wcyc(2);
      t_reset();
      t_basic();
      t_short_retry();
      t_req_fall();
      t_no_latch();
      t_open_on();
      t_open_off();
      t_hot();
      t_ov();
      t_sleep();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      wcyc(20000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule